// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Core

This block is a synthesizable model of a small programmable logic core built on a shared AND array. It has ten dedicated input pins and eight macrocell pins. A static configuration selects the array connections, each macrocell's output polarity, and whether each macrocell is registered, combinatorial or an input. It also selects one global mode: registered, complex or simple. Each pin is modelled as separate input, output-data and output-enable signals, so the surrounding fabric or testbench decides what a shared wire carries.

The array receives sixteen signals: eight come from dedicated inputs and eight from feedback columns. Each signal is offered in true and complement form. Each macrocell owns eight product terms. The mode decides how those terms are split between the sum and the output enable, and what each feedback column carries. In registered mode, dedicated pin 0 acts as the common register clock and dedicated pin 9 as the common active-low output enable. The design samples both with the system clock. A rising edge of pin 0 is detected and loads the macrocell registers on the same system clock edge that first sees pin 0 high.

Top module: `sop_logic_core`

## Requirements
- R1: A synchronous reset clears every macrocell register to 0. A registered macrocell drives the inverse of its register, so after reset it reads 1 whenever it is enabled.
- R2: Array signal s (0..7) is `pin_in[s+1]`, and signal 8+k is feedback column k. Fuse column 2s tests signal s true and column 2s+1 tests it complemented. Term p of macrocell m occupies `cfg_fuse[(m*8+p)*32 +: 32]`. A term is the AND of every column whose fuse bit is 1, so a term with all 32 bits set is 0 and a term with none set is 1.
- R3: In registered mode (`cfg_mode`=00), a macrocell with `cfg_reg`=1 and `cfg_input`=0 loads the OR of its eight terms XOR `cfg_inv` on each clock edge where `pin_in[0]` is 1 and was 0 at the previous edge. It drives the inverse of its register, with enable equal to `~pin_in[9]`, and feeds its register value back on column k.
- R4: In registered mode, a macrocell with `cfg_reg`=0 drives the OR of terms 1..7 XOR `cfg_inv`, is enabled by term 0, and feeds back `io_in[k]`.
- R5: In registered and complex modes, a macrocell with `cfg_input`=1 never drives its pin; this overrides `cfg_reg`. In every mode, `io_out` reads 0 on any pin whose `io_oe` is 0.
- R6: In complex mode (01), feedback column 0 carries `pin_in[0]` and column 7 carries `pin_in[9]`; the other columns carry `io_in[k]`. Every non-input macrocell drives terms 1..7 XOR `cfg_inv`, enabled by term 0. Registers do not change.
- R7: In simple mode (10), each macrocell drives the OR of all eight terms XOR `cfg_inv` and is enabled unless `cfg_input` is set. Macrocells 3 and 4 are always enabled. Columns 0 and 7 carry `pin_in[0]` and `pin_in[9]`, columns 1..3 carry `io_in[0..2]`, and columns 4..6 carry `io_in[5..7]`.
- R8: Mode code 11 behaves exactly as simple mode.
- R9: Registers hold their value when there is no rising edge on `pin_in[0]`, and in any mode other than registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Global mode: 00 registered, 01 complex, 10/11 simple |
| cfg_fuse | input | 2048 | AND-array connection bits, 32 per product term |
| cfg_reg | input | 8 | Per-macrocell registered select |
| cfg_input | input | 8 | Per-macrocell input-only select |
| cfg_inv | input | 8 | Per-macrocell polarity XOR bit |
| pin_in | input | 10 | Dedicated input pins; bit 0 register clock, bit 9 active-low enable in registered mode |
| io_in | input | 8 | Sensed value of each macrocell pin |
| io_out | output | 8 | Data driven onto each macrocell pin |
| io_oe | output | 8 | Output enable of each macrocell pin |

## Verification
On every cycle, the assertions check the following relationships between the registers and the pins:
- reset clearing;
- register hold without a rising edge or outside registered mode;
- inverted register output gated by the shared enable pin;
- silence of input macrocells;
- constant enable of the two centre macrocells in simple mode.

Only the bench's scenarios can show that the array evaluates the intended functions. These scenarios cover a three-bit counter, a one-of-eight decoder, a tri-state bus driver, and the mode-specific feedback routing. Random configurations are then compared against a behavioural reference in all four mode codes.

// File: rtl/sop_pkg.sv
`timescale 1ns/1ps
package sop_pkg;

    localparam int NUM_MC     = 8;
    localparam int NUM_DED    = 10;
    localparam int PT_PER_MC  = 8;
    localparam int NUM_ARR_IN = NUM_DED - 2;
    localparam int NUM_SIG    = NUM_ARR_IN + NUM_MC;
    localparam int NUM_COL    = 2 * NUM_SIG;
    localparam int NUM_PT     = NUM_MC * PT_PER_MC;
    localparam int FUSE_W     = NUM_PT * NUM_COL;
    localparam int CTR_LO     = NUM_MC / 2 - 1;
    localparam int CTR_HI     = NUM_MC / 2;
    localparam int CK_PIN     = 0;
    localparam int OE_PIN     = NUM_DED - 1;

    typedef enum logic [1:0] {
        MODE_REG      = 2'b00,
        MODE_CPLX     = 2'b01,
        MODE_SIMP     = 2'b10,
        MODE_SIMP_ALT = 2'b11
    } core_mode_e;

    typedef struct packed {
        logic is_reg;
        logic is_input;
        logic inv;
    } mc_cfg_t;

    typedef struct packed {
        logic drive;
        logic en;
    } pin_drv_t;

    // Macrocell whose pin value a feedback column carries in simple mode.
    function automatic int simple_nbr(input int col);
        if (col <= 0 || col >= NUM_MC - 1) return 0;
        if (col < NUM_MC / 2)              return col - 1;
        return col + 1;
    endfunction

    function automatic bit is_centre(input int idx);
        return (idx == CTR_LO) || (idx == CTR_HI);
    endfunction

endpackage

// File: rtl/sop_and_array.sv
`timescale 1ns/1ps
module sop_and_array
    import sop_pkg::*;
(
    input  logic [NUM_SIG-1:0] sig,
    input  logic [FUSE_W-1:0]  fuse,
    output logic [NUM_PT-1:0]  pt
);

    logic [NUM_COL-1:0] lit;

    for (genvar s = 0; s < NUM_SIG; s++) begin : g_lit
        assign lit[2*s]     = sig[s];
        assign lit[2*s + 1] = ~sig[s];
    end

    for (genvar p = 0; p < NUM_PT; p++) begin : g_term
        // A connected column must be true; an open column is ignored.
        assign pt[p] = &(lit | ~fuse[p*NUM_COL +: NUM_COL]);
    end

endmodule

// File: rtl/sop_fb_route.sv
`timescale 1ns/1ps
module sop_fb_route
    import sop_pkg::*;
(
    input  core_mode_e        mode,
    input  logic [NUM_MC-1:0] reg_q,
    input  logic [NUM_MC-1:0] reg_active,
    input  logic [NUM_MC-1:0] io_in,
    input  logic              ck_pin,
    input  logic              oe_pin_n,
    output logic [NUM_MC-1:0] fb_col
);

    for (genvar k = 0; k < NUM_MC; k++) begin : g_col
        localparam int  NBR    = simple_nbr(k);
        localparam bit  EDGE_L = (k == 0);
        localparam bit  EDGE_H = (k == NUM_MC - 1);

        always_comb begin
            case (mode)
                MODE_REG: fb_col[k] = reg_active[k] ? reg_q[k] : io_in[k];
                MODE_CPLX: begin
                    if (EDGE_L)      fb_col[k] = ck_pin;
                    else if (EDGE_H) fb_col[k] = oe_pin_n;
                    else             fb_col[k] = io_in[k];
                end
                default: begin
                    if (EDGE_L)      fb_col[k] = ck_pin;
                    else if (EDGE_H) fb_col[k] = oe_pin_n;
                    else             fb_col[k] = io_in[NBR];
                end
            endcase
        end
    end

endmodule

// File: rtl/sop_macrocell.sv
`timescale 1ns/1ps
module sop_macrocell
    import sop_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  core_mode_e           mode,
    input  mc_cfg_t              cfg,
    input  logic [PT_PER_MC-1:0] pt,
    input  logic                 ck_rise,
    input  logic                 oe_pin_n,
    output logic                 q,
    output logic                 reg_active,
    output pin_drv_t             drv
);

    localparam bit CENTRE = is_centre(IDX);

    logic sum_all, sum_tail, data, en;

    assign sum_all    = |pt;
    assign sum_tail   = |pt[PT_PER_MC-1:1];
    assign reg_active = (mode == MODE_REG) && cfg.is_reg && !cfg.is_input;

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (reg_active && ck_rise)
            q <= sum_all ^ cfg.inv;
    end

    always_comb begin
        case (mode)
            MODE_REG: begin
                if (cfg.is_input) begin
                    data = 1'b0;
                    en   = 1'b0;
                end else if (cfg.is_reg) begin
                    data = ~q;
                    en   = ~oe_pin_n;
                end else begin
                    data = sum_tail ^ cfg.inv;
                    en   = pt[0];
                end
            end
            MODE_CPLX: begin
                data = sum_tail ^ cfg.inv;
                en   = pt[0] && !cfg.is_input;
            end
            default: begin
                data = sum_all ^ cfg.inv;
                en   = CENTRE || !cfg.is_input;
            end
        endcase
        drv.drive = data & en;
        drv.en    = en;
    end

endmodule

// File: rtl/sop_logic_core.sv
`timescale 1ns/1ps
module sop_logic_core
    import sop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cfg_mode,
    input  logic [FUSE_W-1:0] cfg_fuse,
    input  logic [NUM_MC-1:0] cfg_reg,
    input  logic [NUM_MC-1:0] cfg_input,
    input  logic [NUM_MC-1:0] cfg_inv,
    input  logic [NUM_DED-1:0] pin_in,
    input  logic [NUM_MC-1:0] io_in,
    output logic [NUM_MC-1:0] io_out,
    output logic [NUM_MC-1:0] io_oe
);

    core_mode_e          mode;
    logic                ck_prev, ck_rise;
    logic [NUM_MC-1:0]   reg_q, reg_active, fb_col;
    logic [NUM_SIG-1:0]  sig;
    logic [NUM_PT-1:0]   pt;

    assign mode = core_mode_e'(cfg_mode);

    always_ff @(posedge clk) begin
        if (rst) ck_prev <= 1'b1;
        else     ck_prev <= pin_in[CK_PIN];
    end
    assign ck_rise = pin_in[CK_PIN] & ~ck_prev;

    sop_fb_route u_route (
        .mode       (mode),
        .reg_q      (reg_q),
        .reg_active (reg_active),
        .io_in      (io_in),
        .ck_pin     (pin_in[CK_PIN]),
        .oe_pin_n   (pin_in[OE_PIN]),
        .fb_col     (fb_col)
    );

    assign sig = {fb_col, pin_in[NUM_DED-2:1]};

    sop_and_array u_array (
        .sig  (sig),
        .fuse (cfg_fuse),
        .pt   (pt)
    );

    for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
        mc_cfg_t  mcfg;
        pin_drv_t drv;

        assign mcfg = '{is_reg: cfg_reg[m], is_input: cfg_input[m], inv: cfg_inv[m]};

        sop_macrocell #(.IDX(m)) u_mc (
            .clk        (clk),
            .rst        (rst),
            .mode       (mode),
            .cfg        (mcfg),
            .pt         (pt[m*PT_PER_MC +: PT_PER_MC]),
            .ck_rise    (ck_rise),
            .oe_pin_n   (pin_in[OE_PIN]),
            .q          (reg_q[m]),
            .reg_active (reg_active[m]),
            .drv        (drv)
        );

        assign io_out[m] = drv.drive;
        assign io_oe[m]  = drv.en;
    end

endmodule

// File: rtl/sop_core_checker.sv
`timescale 1ns/1ps
module sop_core_checker
    import sop_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        cfg_mode,
    input logic [NUM_MC-1:0] cfg_reg,
    input logic [NUM_MC-1:0] cfg_input,
    input logic              ck_pin,
    input logic              oe_pin_n,
    input logic [NUM_MC-1:0] io_out,
    input logic [NUM_MC-1:0] io_oe,
    input logic [NUM_MC-1:0] reg_q
);

    logic [NUM_MC-1:0] regmask;
    assign regmask = cfg_reg & ~cfg_input;

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (reg_q == '0));

    a_r9_hold_no_edge: assert property (@(posedge clk) disable iff (rst)
        !ck_pin |=> $stable(reg_q));

    a_r9_hold_other_mode: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode != 2'b00) |=> $stable(reg_q));

    a_r3_inverted_out: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b00) |-> (((io_out ^ ~reg_q) & regmask & io_oe) == '0));

    a_r3_shared_enable: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b00) |-> (((io_oe ^ {NUM_MC{~oe_pin_n}}) & regmask) == '0));

    a_r5_input_silent: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode[1] |-> ((io_oe & cfg_input) == '0));

    a_r7_centre_on: assert property (@(posedge clk) disable iff (rst)
        cfg_mode[1] |-> (&io_oe[CTR_HI:CTR_LO]));

endmodule

bind sop_logic_core sop_core_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_mode  (cfg_mode),
    .cfg_reg   (cfg_reg),
    .cfg_input (cfg_input),
    .ck_pin    (pin_in[0]),
    .oe_pin_n  (pin_in[9]),
    .io_out    (io_out),
    .io_oe     (io_oe),
    .reg_q     (reg_q)
);

// File: tb/test_sop_logic_core.sv
`timescale 1ns/1ps
module test_sop_logic_core;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cfg_mode = 2'b00;
    logic [2047:0] fz = '1;
    logic [7:0]    cfg_reg = 8'hFF, cfg_input = 8'h00, cfg_inv = 8'h00;
    logic [9:0]    pi = '0;
    logic [7:0]    ioi = '0;
    logic [7:0]    io_out, io_oe;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] mq = '0;
    logic       mprev = 1'b1;
    bit         done = 0;

    always #2 clk = ~clk;

    sop_logic_core i_sop_logic_core (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_fuse(fz),
        .cfg_reg(cfg_reg), .cfg_input(cfg_input), .cfg_inv(cfg_inv),
        .pin_in(pi), .io_in(ioi), .io_out(io_out), .io_oe(io_oe)
    );

    // ---------------- behavioural reference ----------------
    function automatic logic [15:0] m_sig(logic [1:0] md, logic [7:0] q, logic [9:0] pv, logic [7:0] io);
        logic [15:0] s;
        for (int j = 0; j < 8; j++) s[j] = pv[j+1];
        for (int k = 0; k < 8; k++) begin
            if (md == 2'b00)      s[8+k] = (cfg_reg[k] && !cfg_input[k]) ? q[k] : io[k];
            else if (k == 0)      s[8+k] = pv[0];
            else if (k == 7)      s[8+k] = pv[9];
            else if (md == 2'b01) s[8+k] = io[k];
            else if (k < 4)       s[8+k] = io[k-1];
            else                  s[8+k] = io[k+1];
        end
        return s;
    endfunction

    function automatic logic [63:0] m_terms(logic [15:0] s);
        logic [63:0] t;
        for (int pp = 0; pp < 64; pp++) begin
            t[pp] = 1'b1;
            for (int c = 0; c < 32; c++) begin
                logic v;
                v = (c % 2 == 0) ? s[c/2] : !s[c/2];
                if (fz[pp*32 + c] && !v) t[pp] = 1'b0;
            end
        end
        return t;
    endfunction

    function automatic logic [15:0] m_eval(logic [1:0] md, logic [7:0] q, logic [9:0] pv, logic [7:0] io);
        logic [63:0] t;
        logic [7:0] o, e;
        logic full, tail, dat, en;
        t = m_terms(m_sig(md, q, pv, io));
        for (int m = 0; m < 8; m++) begin
            full = |t[m*8 +: 8];
            tail = |t[m*8+1 +: 7];
            if (md == 2'b00) begin
                if (cfg_input[m])    begin dat = 1'b0; en = 1'b0; end
                else if (cfg_reg[m]) begin dat = !q[m]; en = !pv[9]; end
                else                 begin dat = tail ^ cfg_inv[m]; en = t[m*8]; end
            end else if (md == 2'b01) begin
                dat = tail ^ cfg_inv[m];
                en  = t[m*8] && !cfg_input[m];
            end else begin
                dat = full ^ cfg_inv[m];
                en  = (m == 3) || (m == 4) || !cfg_input[m];
            end
            o[m] = dat & en;
            e[m] = en;
        end
        return {e, o};
    endfunction

    function automatic logic [7:0] m_next(logic [7:0] q);
        logic [63:0] t;
        logic [7:0] nq;
        t  = m_terms(m_sig(cfg_mode, q, pi, ioi));
        nq = q;
        for (int m = 0; m < 8; m++)
            if (cfg_mode == 2'b00 && cfg_reg[m] && !cfg_input[m])
                nq[m] = (|t[m*8 +: 8]) ^ cfg_inv[m];
        return nq;
    endfunction

    // ---------------- checking ----------------
    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one clock: model advances at the edge, outputs compared 1 ns later
    task automatic step(string tag);
        logic [15:0] ex;
        @(posedge clk);
        if (rst) begin
            mq = '0; mprev = 1'b1;
        end else begin
            if (pi[0] && !mprev) mq = m_next(mq);
            mprev = pi[0];
        end
        #1;
        ex = m_eval(cfg_mode, mq, pi, ioi);
        n_cmp++;
        if ({io_oe, io_out} !== ex) begin
            n_bad++;
            $display("FAIL %s: actual oe/out %h/%h expected %h/%h", tag, io_oe, io_out, ex[15:8], ex[7:0]);
        end
        @(negedge clk);
    endtask

    task automatic clr(int m, int p); fz[(m*8+p)*32 +: 32] = '0; endtask
    task automatic lit(int m, int p, int s, bit neg); fz[(m*8+p)*32 + 2*s + int'(neg)] = 1'b1; endtask

    task automatic rand_run(logic [1:0] md, string tag, int n);
        cfg_mode = md; cfg_reg = 8'($urandom); cfg_input = 8'($urandom & $urandom); cfg_inv = 8'($urandom);
        fz = '1;
        for (int pp = 0; pp < 64; pp++) begin
            if ($urandom % 4 != 0) begin
                fz[pp*32 +: 32] = '0;
                for (int i = 0; i <= int'($urandom % 3); i++) fz[pp*32 + int'($urandom % 32)] = 1'b1;
            end
        end
        for (int i = 0; i < n; i++) begin
            pi = 10'($urandom); ioi = 8'($urandom);
            step(tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state with registered macrocells and blank array
        repeat (3) step("R1");
        rst = 1'b0;
        step("R1");
        chk("R1 out after reset", io_out, 8'hFF);
        chk("R3 shared enable low", io_oe, 8'hFF);
        pi[9] = 1'b1; step("R3");
        chk("R3 shared enable high", io_oe, 8'h00);
        chk("R5 quiet when off", io_out, 8'h00);
        pi[9] = 1'b0;

        // R3: three-bit counter on macrocells 0..2
        clr(0,0); lit(0,0,8,1);
        clr(1,0); lit(1,0,9,0); lit(1,0,8,1);
        clr(1,1); lit(1,1,9,1); lit(1,1,8,0);
        clr(2,0); lit(2,0,10,0); lit(2,0,9,1);
        clr(2,1); lit(2,1,10,0); lit(2,1,8,1);
        clr(2,2); lit(2,2,10,1); lit(2,2,9,0); lit(2,2,8,0);
        for (int e = 1; e <= 10; e++) begin
            pi[0] = 1'b1; step("R3");
            chk("R3 counter", io_out, {5'b11111, ~3'(e)});
            pi[0] = 1'b0; step("R3");
        end
        // R9: no edge, then other mode, then back
        pi[0] = 1'b1; repeat (4) step("R9");
        chk("R9 hold on steady clock pin", io_out, {5'b11111, ~3'd3});
        cfg_mode = 2'b01;
        for (int i = 0; i < 4; i++) begin pi[0] = ~pi[0]; step("R9"); end
        cfg_mode = 2'b00; pi[0] = 1'b0; step("R9");
        chk("R9 hold outside registered mode", io_out, {5'b11111, ~3'd3});
        rst = 1'b1; step("R1"); rst = 1'b0;
        chk("R1 mid-run reset", io_out, 8'hFF);

        // R4 / R5: combinatorial and input macrocells in registered mode
        fz = '1; cfg_reg = 8'h40; cfg_input = 8'h40; cfg_inv = 8'h20;
        clr(5,0); clr(5,1); lit(5,1,1,0);
        clr(4,0); clr(4,1); lit(4,1,12,0);
        clr(6,0);
        pi = '0; ioi = 8'h10; step("R4");
        chk("R4 enables", io_oe, 8'h30);
        chk("R4 data with pin feedback", io_out, 8'h30);
        pi[2] = 1'b1; ioi = 8'h00; step("R4");
        chk("R4 data inverted", io_out, 8'h00);
        chk("R5 input macrocell off", io_oe & 8'h40, 8'h00);

        // R6: tri-state bus driver in complex mode
        fz = '1; cfg_mode = 2'b01; cfg_reg = '0; cfg_input = '0; cfg_inv = '0;
        for (int m = 0; m < 8; m++) begin
            clr(m,0); lit(m,0,0,0);
            clr(m,1); lit(m,1,15,0);
        end
        clr(2,2); lit(2,2,8,0);
        pi = '0; pi[1] = 1'b1; pi[9] = 1'b1; step("R6");
        chk("R6 bus driven high", io_out, 8'hFF);
        chk("R6 bus enabled", io_oe, 8'hFF);
        pi[9] = 1'b0; pi[0] = 1'b1; step("R6");
        chk("R6 column 0 carries clock pin", io_out, 8'h04);
        pi[1] = 1'b0; step("R6");
        chk("R6 bus released", io_oe, 8'h00);

        // R7: one-of-eight decoder in simple mode
        fz = '1; cfg_mode = 2'b10; pi = '0; ioi = '0;
        for (int m = 0; m < 8; m++) begin
            clr(m,0);
            for (int b = 0; b < 3; b++) lit(m,0,b,!m[b]);
        end
        for (int v = 0; v < 8; v++) begin
            pi = 10'(v << 1); step("R7");
            chk("R7 decoder", io_out, 8'(1 << v));
        end
        cfg_input = 8'hFF; step("R7");
        chk("R7 centre always on", io_oe, 8'h18);
        cfg_input = 8'h00;
        fz = '1; clr(3,0); lit(3,0,9,0);
        pi = '0; ioi = 8'h01; step("R7");
        chk("R7 neighbour feedback set", io_out, 8'h08);
        ioi = 8'hFE; step("R7");
        chk("R7 neighbour feedback clear", io_out, 8'h00);
        cfg_mode = 2'b11; ioi = 8'h01; step("R8");
        chk("R8 alternate code as simple", io_out, 8'h08);

        // random configurations compared against the reference every cycle
        for (int r = 0; r < 4; r++) begin
            rand_run(2'b00, "R2/R3/R4/R5/R9", 120);
            rand_run(2'b01, "R2/R6", 120);
            rand_run(2'b10, "R2/R7", 120);
            rand_run(2'b11, "R8", 60);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule